// File: doc/BRIEF.md
# Settings Persistence Controller

This block keeps the three settings of a dual-channel attenuator: two wiper codes and a three-bit configuration field. It holds the live copies that drive the attenuator and a modelled nonvolatile bank that survives a power cycle. A protocol front end hands it decoded writes, a bus STOP event and a zero-crossing-complete event. The block decides when the bank is rewritten, and it holds `busy` high for the whole write time. The front end uses `busy` to withhold its address acknowledge.

The configuration field has three bits. Bit 2 selects volatile wipers (1) or stored wipers (0). Bit 1 enables zero-crossing gating. Bit 0 selects the 34-position taper (1, mute code 33) or the 64-position taper (0, mute code 63). A wiper write with gating enabled opens a zero-crossing window. A commit cannot start while that window is open. On a `power_up` pulse the live configuration is reloaded from the bank. The wipers are reloaded as well, or they come up at the mute code of the stored taper when the stored mode is volatile.

Top module: `nv_settings_keeper`

## Requirements
- R1: After `rst_n` low, `cfg_byte` reads 87h, both wipers read 33 (mute of the 34-position taper), `busy` is 0, and the bank holds the same three values.
- R2: An accepted write with `wr_sel` 00 sets `wiper0`, and one with 01 sets `wiper1`, each to `wr_data`, visible one cycle later. With `wr_sel` 10, `wr_data[2:0]` becomes the configuration field, and `cfg_byte` reads {2'b10, 3'b000, field}. With `wr_sel` 11 nothing changes.
- R3: On `power_up`, if the stored bit 2 is 0, the wipers and the configuration take the stored values.
- R4: On `power_up`, if the stored bit 2 is 1, the configuration takes the stored value and both wipers take the mute code: 33 when stored bit 0 is 1, 63 when it is 0.
- R5: A commit starts only after `stop_evt`. `busy` rises in the cycle after the enabling event (the STOP itself, or the closing `zc_done`).
- R6: After a wiper write made while bit 1 is 1, the commit waits for `zc_done`. A configuration-only transaction starts its commit right after the STOP.
- R7: `busy` stays high for exactly `COMMIT_CYCLES` cycles.
- R8: Each commit stores all three live values, including wiper values that were written only in volatile mode.
- R9: Wiper writes made while live bit 2 is 1 do not start a commit at STOP, and they leave the bank unchanged.
- R10: A STOP with no preceding write in the transaction does not raise `busy`.
- R11: While `busy` is high, writes and STOP events are ignored.
- R12: `power_up` during a commit drops `busy`, and the bank keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low factory reset of live and stored values |
| power_up | input | 1 | One-cycle pulse modelling a power cycle; reloads live values from the bank |
| wr_en | input | 1 | Decoded byte write from the protocol front end |
| wr_sel | input | 2 | Write target: 00 wiper0, 01 wiper1, 10 configuration, 11 none |
| wr_data | input | WW | Payload bits of the written byte |
| stop_evt | input | 1 | One-cycle pulse on a bus STOP |
| zc_done | input | 1 | One-cycle pulse when the zero-crossing window completes |
| wiper0 | output | WW | Live wiper code, channel 0 |
| wiper1 | output | WW | Live wiper code, channel 1 |
| cfg_byte | output | 8 | Live configuration byte |
| busy | output | 1 | Commit in progress |

## Verification
The bench builds the block with `COMMIT_CYCLES` = 7 and the default 6-bit wiper width. This keeps every commit short enough to measure its length on each run. It also makes it cheap to sweep all 64 codes on both wipers and all eight configuration fields. Each configuration goes through a full write, STOP, optional zero-crossing wait, commit and power cycle. The reloaded values then show both stored and muted start-up for every taper and gating combination.

// File: rtl/nv_settings_keeper.sv
module nv_settings_keeper #(
  parameter int unsigned WW            = 6,
  parameter int unsigned COMMIT_CYCLES = 1000000,
  parameter int unsigned MUTE_LONG     = 63,
  parameter int unsigned MUTE_SHORT    = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_up,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [WW-1:0] wr_data,
  input  logic          stop_evt,
  input  logic          zc_done,
  output logic [WW-1:0] wiper0,
  output logic [WW-1:0] wiper1,
  output logic [7:0]    cfg_byte,
  output logic          busy
);

  localparam int unsigned CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [WW-1:0] M_LONG  = MUTE_LONG[WW-1:0];
  localparam logic [WW-1:0] M_SHORT = MUTE_SHORT[WW-1:0];
  localparam logic [2:0] CFG_FACTORY = 3'b111;

  logic [WW-1:0] w0, w1, nv_w0, nv_w1;
  logic [2:0]    cf, nv_cf;
  logic          pending, armed, win;
  logic [CW-1:0] cnt;

  function automatic logic [WW-1:0] mute_code(input logic short_taper);
    return short_taper ? M_SHORT : M_LONG;
  endfunction

  wire accept = wr_en & ~busy;
  wire wr_w   = accept & ~wr_sel[1];
  wire wr_c   = accept & (wr_sel == 2'b10);
  wire vol    = cf[2];
  wire zce    = cf[1];
  wire start  = ~busy & ~wr_en & (stop_evt | armed) & pending & (~win | zc_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_w0   <= M_SHORT;
      nv_w1   <= M_SHORT;
      nv_cf   <= CFG_FACTORY;
      w0      <= M_SHORT;
      w1      <= M_SHORT;
      cf      <= CFG_FACTORY;
      pending <= 1'b0;
      armed   <= 1'b0;
      win     <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (power_up) begin
      w0      <= nv_cf[2] ? mute_code(nv_cf[0]) : nv_w0;
      w1      <= nv_cf[2] ? mute_code(nv_cf[0]) : nv_w1;
      cf      <= nv_cf;
      pending <= 1'b0;
      armed   <= 1'b0;
      win     <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
    end else begin
      if (wr_w && !wr_sel[0]) w0 <= wr_data;
      if (wr_w &&  wr_sel[0]) w1 <= wr_data;
      if (wr_c) cf <= wr_data[2:0];

      if (start) pending <= 1'b0;
      else if (wr_c || (wr_w && !vol)) pending <= 1'b1;

      if (wr_w && zce) win <= 1'b1;
      else if (zc_done) win <= 1'b0;

      if (start) armed <= 1'b0;
      else if (stop_evt && !busy && pending) armed <= 1'b1;

      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(COMMIT_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy  <= 1'b0;
          nv_w0 <= w0;
          nv_w1 <= w1;
          nv_cf <= cf;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign wiper0   = w0;
  assign wiper1   = w1;
  assign cfg_byte = {5'b10000, cf};

  assert_busy_freezes_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !power_up) |=> (wiper0 == $past(wiper0) && wiper1 == $past(wiper1)
                                      && cfg_byte == $past(cfg_byte)));

  assert_start_needs_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_evt) || $past(armed)));

  assert_waits_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(win) || $past(zc_done)));

  assert_idle_stop_no_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !pending && !armed && !busy) |=> !busy);

  assert_powerup_aborts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    power_up |=> (!busy && !armed));

endmodule

// File: tb/nv_settings_keeper_bench.sv
`timescale 1ns/1ps
module nv_settings_keeper_bench;
  localparam int WW = 6;
  localparam int NC = 7;

  logic clk = 1'b0;
  logic rst_n, power_up, wr_en, stop_evt, zc_done;
  logic [1:0] wr_sel;
  logic [WW-1:0] wr_data;
  logic [WW-1:0] wiper0, wiper1;
  logic [7:0] cfg_byte;
  logic busy;

  int checks = 0, errors = 0;
  int ew0, ew1, ec, bw0, bw1, bc;

  always #2.5 clk = ~clk;

  nv_settings_keeper #(.WW(WW), .COMMIT_CYCLES(NC)) u_nv_settings_keeper (
    .clk(clk), .rst_n(rst_n), .power_up(power_up), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .stop_evt(stop_evt), .zc_done(zc_done),
    .wiper0(wiper0), .wiper1(wiper1), .cfg_byte(cfg_byte), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mute(input int c);
    return (c & 1) ? 33 : 63;
  endfunction

  task automatic check_live(input string req);
    chk(req, int'(wiper0), ew0);
    chk(req, int'(wiper1), ew1);
    chk(req, int'(cfg_byte), 128 + ec);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = WW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic pulse_zc();
    zc_done = 1'b1; @(negedge clk); zc_done = 1'b0;
  endtask

  task automatic pulse_pwr();
    power_up = 1'b1; @(negedge clk); power_up = 1'b0;
    ec  = bc;
    ew0 = (bc & 4) ? mute(bc) : bw0;
    ew1 = (bc & 4) ? mute(bc) : bw1;
  endtask

  task automatic wait_commit(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    bw0 = ew0; bw1 = ew1; bc = ec;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; power_up = 1'b0; wr_en = 1'b0; stop_evt = 1'b0; zc_done = 1'b0;
    wr_sel = 2'b00; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ec = 7; bc = 7; ew0 = 33; ew1 = 33; bw0 = 33; bw1 = 33;
    chk("R1", int'(cfg_byte), 8'h87);
    check_live("R1");
    chk("R1", int'(busy), 0);

    pulse_stop();
    for (int i = 0; i < 3; i++) begin chk("R10", int'(busy), 0); @(negedge clk); end

    for (int v = 0; v < 64; v++) begin
      wr(0, v); ew0 = v;
      wr(1, 63 - v); ew1 = 63 - v;
      check_live("R2");
    end
    wr(3, 21);
    check_live("R2");

    pulse_stop();
    for (int i = 0; i < 3; i++) begin chk("R9", int'(busy), 0); @(negedge clk); end
    pulse_pwr();
    check_live("R9");

    for (int c = 0; c < 8; c++) begin
      wr(2, 6'h38 | c); ec = c;
      chk("R2", int'(cfg_byte), 128 + c);
      ew0 = (5 * c + 3) % 64; wr(0, ew0);
      ew1 = (9 * c + 1) % 64; wr(1, ew1);
      pulse_stop();
      if (c & 2) begin
        for (int i = 0; i < 3; i++) begin chk("R6", int'(busy), 0); @(negedge clk); end
        pulse_zc();
        chk("R6", int'(busy), 1);
      end else begin
        chk("R5", int'(busy), 1);
      end
      wait_commit(n);
      chk("R7", n, NC);
      pulse_pwr();
      check_live((c & 4) ? "R4" : "R3");
      chk("R3", int'(busy), 0);
    end

    wr(0, 12); ew0 = 12;
    wr(1, 45); ew1 = 45;
    pulse_zc();
    wr(2, 0); ec = 0;
    pulse_stop();
    chk("R8", int'(busy), 1);
    wait_commit(n);
    chk("R8", n, NC);
    pulse_pwr();
    chk("R8", int'(wiper0), 12);
    chk("R8", int'(wiper1), 45);

    wr(0, 20); ew0 = 20;
    pulse_stop();
    chk("R11", int'(busy), 1);
    wr(0, 5);
    wr(2, 7);
    pulse_stop();
    check_live("R11");
    wait_commit(n);
    for (int i = 0; i < 3; i++) begin chk("R11", int'(busy), 0); @(negedge clk); end

    wr(1, 30); ew1 = 30;
    pulse_stop();
    chk("R12", int'(busy), 1);
    @(negedge clk);
    pulse_pwr();
    chk("R12", int'(busy), 0);
    check_live("R12");
    chk("R12", int'(wiper1), 45);

    wr(2, 2); ec = 2;
    pulse_stop();
    chk("R6", int'(busy), 1);
    wait_commit(n);
    chk("R7", n, NC);
    pulse_pwr();
    check_live("R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule